// File: doc/BRIEF.md
# Shared Interrupt Distributor with Per-CPU Claim Interfaces

This block collects level-sensitive peripheral interrupt lines for a small symmetric multiprocessor. A single global distributor holds the enable bit, the CPU route mask and the in-service state of every shared source. Each CPU has its own interface instance that holds that CPU's private sources: sixteen software-generated interrupts that any CPU can raise at a chosen set of CPUs, and one level-sensitive local timer line.

Every CPU reaches the block through its own simple request port (valid, write, offset, data) and uses the same offsets as every other CPU. A read of the claim offset hands the reading CPU exactly one deliverable interrupt and marks it in service. A write of that ID to the completion offset ends service. Claims made by several CPUs in the same cycle are resolved at once, so no interrupt is ever handed out twice. A CPU that finds nothing left gets the reserved idle ID 1023. A per-CPU request output tells each CPU when a claim would succeed.

Top module: `irqd_top`

## Requirements
- R1: After reset every irq_o bit is low, no response is pending, all shared sources are disabled with an empty route mask, and nothing is in service, so a claim read returns 1023.
- R2: Every read request gets rsp_vld on the next cycle. A claim read (offset 0) returns the ID in rsp_data[9:0] with the upper bits zero, and a read of any other offset returns 0. All CPUs use the same offsets, and each access touches only that CPU's private state.
- R3: Shared source i has ID 32+i. It can be delivered to CPU c only while its line is high, its enable bit i is set, and bit c of its route mask is set. Offset 3 writes the whole enable word. Offset 4 writes a route mask, with wdata[4:0] selecting the source and wdata[19:16] holding the mask.
- R4: A shared interrupt goes to at most one CPU. When several CPUs claim in the same cycle they are served in ascending CPU index, each gets a different ID, and a CPU with nothing deliverable left gets 1023.
- R5: A claim returns the lowest deliverable ID. Software-generated IDs 0 to 15 come first, then the timer ID 29, then shared IDs in ascending order.
- R6: An interrupt in service is not delivered again until its owner writes its ID to offset 1 (wdata[9:0]). A completion write for a shared ID from a CPU that does not own it has no effect. After completion, a shared source whose line is still high can be claimed again by any CPU in its route mask.
- R7: A write to offset 2 raises software-generated interrupt wdata[3:0] at each CPU named in wdata[19:16]. A claim clears that pending bit and starts service, and only the named CPUs can see the interrupt.
- R8: Input tmr_i[c] is CPU c's level-sensitive timer with ID 29. No other CPU can see it.
- R9: irq_o[c] is high exactly when a claim by CPU c in that cycle would return an ID other than 1023, assuming no lower-index CPU claims at the same time.
- R10: When several CPUs write distributor configuration in the same cycle, the writes are applied in ascending CPU index, so the highest index wins.
- R11: A shared line that falls before it is claimed leaves nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_i | input | NSPI | Shared peripheral interrupt lines, level-sensitive |
| tmr_i | input | NCPU | Per-CPU local timer lines |
| req_vld | input | NCPU | Per-CPU request valid |
| req_wr | input | NCPU | Per-CPU request is a write |
| req_addr | input | NCPU*4 | Per-CPU register offset |
| req_wdata | input | NCPU*32 | Per-CPU write data |
| rsp_vld | output | NCPU | Per-CPU read response valid, one cycle after the read |
| rsp_data | output | NCPU*32 | Per-CPU read data |
| irq_o | output | NCPU | Per-CPU interrupt request |

## Verification
Wrong in-service or owner state shows up as a duplicate ID when claims collide, or as an ID delivered again before completion. Either error appears in rsp_data one cycle after the claim. A lost pending bit or a wrong route mask shows up at once as an irq_o bit that disagrees with what the CPU could claim, and then as an unexpected 1023 on the next claim. Since any state error reaches the ports within a cycle or two, the bench compares irq_o on every cycle and every read response against its own model, across random request mixes and directed collisions.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int IDW     = 10;
  localparam int DW      = 32;
  localparam int AW      = 4;
  localparam int NSGI    = 16;
  localparam int SW      = $clog2(NSGI);
  localparam int TGT_LSB = 16;
  localparam logic [IDW-1:0] ID_SPUR  = 10'd1023;
  localparam logic [IDW-1:0] ID_TMR   = 10'd29;
  localparam logic [IDW-1:0] SPI_BASE = 10'd32;
  localparam logic [IDW-1:0] SGI_END  = 10'd16;
  localparam logic [AW-1:0] OFS_ACK   = 4'd0;
  localparam logic [AW-1:0] OFS_EOI   = 4'd1;
  localparam logic [AW-1:0] OFS_SGI   = 4'd2;
  localparam logic [AW-1:0] OFS_EN    = 4'd3;
  localparam logic [AW-1:0] OFS_ROUTE = 4'd4;
endpackage

// File: rtl/irqd_lowest.sv
module irqd_lowest #(
  parameter int W = 32,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |vec;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irqd_cpu_priv.sv
module irqd_cpu_priv
  import irqd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tmr_i,
  input  logic [NSGI-1:0] sgi_set,
  input  logic            claim,
  input  logic            eoi_vld,
  input  logic [IDW-1:0]  eoi_id,
  output logic            hit,
  output logic [IDW-1:0]  id
);
  logic [NSGI-1:0] pend_q, pend_d, act_q, act_d;
  logic            tact_q, tact_d;
  logic [NSGI-1:0] sgi_rdy;
  logic            sgi_hit, tmr_rdy;
  logic [SW-1:0]   sgi_idx;

  assign sgi_rdy = pend_q & ~act_q;
  assign tmr_rdy = tmr_i & ~tact_q;

  irqd_lowest #(.W(NSGI)) u_sgi_pick (.vec(sgi_rdy), .hit(sgi_hit), .idx(sgi_idx));

  assign hit = sgi_hit | tmr_rdy;
  assign id  = sgi_hit ? IDW'(sgi_idx) : ID_TMR;

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    tact_d = tact_q;
    if (claim && sgi_hit) begin
      pend_d[sgi_idx] = 1'b0;
      act_d[sgi_idx]  = 1'b1;
    end else if (claim && tmr_rdy) begin
      tact_d = 1'b1;
    end
    if (eoi_vld) begin
      if (eoi_id < SGI_END) act_d[eoi_id[SW-1:0]] = 1'b0;
      else if (eoi_id == ID_TMR) tact_d = 1'b0;
    end
    pend_d = pend_d | sgi_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      tact_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      tact_q <= tact_d;
    end
  end

  for (genvar i = 0; i < NSGI; i++) begin : g_chk
    // R6: software interrupt stays in service until completed
    a_r6_sgi_held: assert property (@(posedge clk) disable iff (!rst_n)
      act_q[i] && !(eoi_vld && eoi_id == IDW'(i)) |=> act_q[i]);
    // R7: a send always leaves the interrupt pending
    a_r7_sgi_raised: assert property (@(posedge clk) disable iff (!rst_n)
      sgi_set[i] |=> pend_q[i]);
  end
endmodule

// File: rtl/irqd_dist.sv
module irqd_dist
  import irqd_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NSPI = 32,
  localparam int CW  = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int SIW = (NSPI > 1) ? $clog2(NSPI) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSPI-1:0]     line_i,
  input  logic [NCPU-1:0]     claim,
  input  logic [NCPU-1:0]     eoi_vld,
  input  logic [NCPU*IDW-1:0] eoi_id,
  input  logic [NCPU-1:0]     en_wr,
  input  logic [NCPU-1:0]     rt_wr,
  input  logic [NCPU*DW-1:0]  wd,
  output logic [NCPU-1:0]     gnt_hit,
  output logic [NCPU*IDW-1:0] gnt_id,
  output logic [NCPU-1:0]     pend_cpu
);
  logic [NSPI-1:0]           en_q, en_d, act_q, act_d, clr, elig;
  logic [NSPI-1:0][NCPU-1:0] tgt_q, tgt_d, gcol;
  logic [NSPI-1:0][CW-1:0]   own_q, own_d;
  logic [NSPI-1:0]           taken   [NCPU+1];
  logic [NSPI-1:0]           gnt_vec [NCPU];

  assign elig     = line_i & en_q & ~act_q;
  assign taken[0] = '0;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [NSPI-1:0] col, avail;
    logic            p_hit;
    logic [SIW-1:0]  p_idx;
    for (genvar s = 0; s < NSPI; s++) begin : g_col
      assign col[s] = tgt_q[s][c];
    end
    assign avail = elig & col & ~taken[c];
    irqd_lowest #(.W(NSPI)) u_pick (.vec(avail), .hit(p_hit), .idx(p_idx));
    assign gnt_hit[c]              = claim[c] & p_hit;
    assign gnt_id[c*IDW +: IDW]    = SPI_BASE + IDW'(p_idx);
    assign gnt_vec[c]              = gnt_hit[c] ? (NSPI'(1) << p_idx) : '0;
    assign taken[c+1]              = taken[c] | gnt_vec[c];
    assign pend_cpu[c]             = |(elig & col);
  end

  always_comb begin
    clr  = '0;
    gcol = '0;
    for (int c = 0; c < NCPU; c++) begin
      for (int s = 0; s < NSPI; s++) begin
        gcol[s][c] = gnt_vec[c][s];
        if (eoi_vld[c] && act_q[s] && own_q[s] == CW'(c) &&
            eoi_id[c*IDW +: IDW] == SPI_BASE + IDW'(s))
          clr[s] = 1'b1;
      end
    end
  end

  always_comb begin
    act_d = act_q & ~clr;
    own_d = own_q;
    en_d  = en_q;
    tgt_d = tgt_q;
    for (int c = 0; c < NCPU; c++) begin
      act_d = act_d | gnt_vec[c];
      for (int s = 0; s < NSPI; s++) begin
        if (gnt_vec[c][s]) own_d[s] = CW'(c);
      end
      if (en_wr[c]) en_d = wd[c*DW +: NSPI];
      if (rt_wr[c]) tgt_d[wd[c*DW +: SIW]] = wd[c*DW + TGT_LSB +: NCPU];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      act_q <= '0;
      tgt_q <= '0;
      own_q <= '0;
    end else begin
      en_q  <= en_d;
      act_q <= act_d;
      tgt_q <= tgt_d;
      own_q <= own_d;
    end
  end

  for (genvar s = 0; s < NSPI; s++) begin : g_chk
    // R4: a source is granted to at most one CPU per cycle
    a_r4_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gcol[s]));
    // R6: ownership holds until the owner completes it
    a_r6_owner_held: assert property (@(posedge clk) disable iff (!rst_n)
      act_q[s] && !clr[s] |=> act_q[s] && $stable(own_q[s]));
  end
endmodule

// File: rtl/irqd_top.sv
module irqd_top
  import irqd_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NSPI = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSPI-1:0]    spi_i,
  input  logic [NCPU-1:0]    tmr_i,
  input  logic [NCPU-1:0]    req_vld,
  input  logic [NCPU-1:0]    req_wr,
  input  logic [NCPU*AW-1:0] req_addr,
  input  logic [NCPU*DW-1:0] req_wdata,
  output logic [NCPU-1:0]    rsp_vld,
  output logic [NCPU*DW-1:0] rsp_data,
  output logic [NCPU-1:0]    irq_o
);
  logic [NCPU-1:0]            rd_ack, wr_eoi, wr_sgi, wr_en, wr_rt;
  logic [NCPU-1:0]            priv_hit, sh_claim, gnt_hit, pend_cpu;
  logic [NCPU*IDW-1:0]        priv_id, gnt_id, eoi_id;
  logic [NCPU-1:0][NSGI-1:0]  sgi_set;
  logic [NCPU-1:0]            rsp_vld_q, rsp_vld_d;
  logic [NCPU-1:0][DW-1:0]    rsp_q, rsp_d;

  for (genvar c = 0; c < NCPU; c++) begin : g_if
    logic [AW-1:0] ofs;
    assign ofs         = req_addr[c*AW +: AW];
    assign rd_ack[c]   = req_vld[c] & ~req_wr[c] & (ofs == OFS_ACK);
    assign wr_eoi[c]   = req_vld[c] &  req_wr[c] & (ofs == OFS_EOI);
    assign wr_sgi[c]   = req_vld[c] &  req_wr[c] & (ofs == OFS_SGI);
    assign wr_en[c]    = req_vld[c] &  req_wr[c] & (ofs == OFS_EN);
    assign wr_rt[c]    = req_vld[c] &  req_wr[c] & (ofs == OFS_ROUTE);
    assign eoi_id[c*IDW +: IDW] = req_wdata[c*DW +: IDW];
    assign sh_claim[c] = rd_ack[c] & ~priv_hit[c];
    assign irq_o[c]    = priv_hit[c] | pend_cpu[c];

    irqd_cpu_priv u_priv (
      .clk     (clk),
      .rst_n   (rst_n),
      .tmr_i   (tmr_i[c]),
      .sgi_set (sgi_set[c]),
      .claim   (rd_ack[c]),
      .eoi_vld (wr_eoi[c]),
      .eoi_id  (eoi_id[c*IDW +: IDW]),
      .hit     (priv_hit[c]),
      .id      (priv_id[c*IDW +: IDW])
    );
  end

  always_comb begin
    sgi_set = '0;
    for (int t = 0; t < NCPU; t++) begin
      for (int s = 0; s < NCPU; s++) begin
        if (wr_sgi[s] && req_wdata[s*DW + TGT_LSB + t])
          sgi_set[t] = sgi_set[t] | (NSGI'(1) << req_wdata[s*DW +: SW]);
      end
    end
  end

  irqd_dist #(.NCPU(NCPU), .NSPI(NSPI)) u_dist (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (spi_i),
    .claim    (sh_claim),
    .eoi_vld  (wr_eoi),
    .eoi_id   (eoi_id),
    .en_wr    (wr_en),
    .rt_wr    (wr_rt),
    .wd       (req_wdata),
    .gnt_hit  (gnt_hit),
    .gnt_id   (gnt_id),
    .pend_cpu (pend_cpu)
  );

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      rsp_vld_d[c] = req_vld[c] & ~req_wr[c];
      rsp_d[c]     = '0;
      if (rd_ack[c]) begin
        if (priv_hit[c])     rsp_d[c] = DW'(priv_id[c*IDW +: IDW]);
        else if (gnt_hit[c]) rsp_d[c] = DW'(gnt_id[c*IDW +: IDW]);
        else                 rsp_d[c] = DW'(ID_SPUR);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld_q <= '0;
      rsp_q     <= '0;
    end else begin
      rsp_vld_q <= rsp_vld_d;
      rsp_q     <= rsp_d;
    end
  end

  assign rsp_vld  = rsp_vld_q;
  assign rsp_data = rsp_q;

  for (genvar c = 0; c < NCPU; c++) begin : g_chk
    // R2: a read is answered on the next cycle
    a_r2_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld[c] && !req_wr[c] |=> rsp_vld[c]);
    // R4: a claim with no request raised yields the idle ID
    a_r4_idle_claim: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack[c] && !irq_o[c] |=> rsp_data[c*DW +: DW] == DW'(ID_SPUR));
    if (c == 0) begin : g_first
      // R9: CPU 0 is never beaten, so a raised request is always honoured
      a_r9_first_served: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack[0] && irq_o[0] |=> rsp_data[DW-1:0] != DW'(ID_SPUR));
    end
  end
endmodule

// File: tb/test_irqd_top.sv
`timescale 1ns/1ps
module test_irqd_top;
  localparam int NC = 4;
  localparam int NS = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NS-1:0]     spi;
  logic [NC-1:0]     tmr;
  logic [NC-1:0]     r_vld, r_wr;
  logic [NC-1:0][3:0]  r_addr;
  logic [NC-1:0][31:0] r_wd;
  logic [NC-1:0]     rsp_vld;
  logic [NC*32-1:0]  rsp_data;
  logic [NC-1:0]     irq;

  always #2.5 clk = ~clk;

  irqd_top #(.NCPU(NC), .NSPI(NS)) i_irqd_top (
    .clk(clk), .rst_n(rst_n), .spi_i(spi), .tmr_i(tmr),
    .req_vld(r_vld), .req_wr(r_wr), .req_addr(r_addr), .req_wdata(r_wd),
    .rsp_vld(rsp_vld), .rsp_data(rsp_data), .irq_o(irq)
  );

  int nchk = 0, nfail = 0;
  bit        m_en [NS];
  bit [3:0]  m_tgt[NS];
  bit        m_act[NS];
  int        m_own[NS];
  bit [15:0] m_sp [NC];
  bit [15:0] m_sa [NC];
  bit        m_ta [NC];
  int        got  [NC];
  int        m_last[NC];

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int claim_one(int c);
    for (int i = 0; i < 16; i++)
      if (m_sp[c][i] && !m_sa[c][i]) begin m_sp[c][i] = 0; m_sa[c][i] = 1; return i; end
    if (tmr[c] && !m_ta[c]) begin m_ta[c] = 1; return 29; end
    for (int s = 0; s < NS; s++)
      if (spi[s] && m_en[s] && !m_act[s] && m_tgt[s][c]) begin
        m_act[s] = 1; m_own[s] = c; return 32 + s;
      end
    return 1023;
  endfunction

  function automatic bit m_irq(int c);
    if ((m_sp[c] & ~m_sa[c]) != 0) return 1;
    if (tmr[c] && !m_ta[c]) return 1;
    for (int s = 0; s < NS; s++)
      if (spi[s] && m_en[s] && !m_act[s] && m_tgt[s][c]) return 1;
    return 0;
  endfunction

  task automatic clr_req();
    r_vld = '0; r_wr = '0; r_addr = '0; r_wd = '0;
  endtask

  task automatic put(int c, bit wr, int ofs, int data);
    r_vld[c] = 1; r_wr[c] = wr; r_addr[c] = 4'(ofs); r_wd[c] = 32'(data);
  endtask

  task automatic step(string tag);
    int  ed[NC];
    bit  ev[NC];
    for (int c = 0; c < NC; c++) begin
      ev[c] = r_vld[c] && !r_wr[c];
      ed[c] = 0;
      if (ev[c] && r_addr[c] == 0) begin
        ed[c] = claim_one(c);
        if (ed[c] != 1023) m_last[c] = ed[c];
      end
    end
    for (int c = 0; c < NC; c++) begin
      if (r_vld[c] && r_wr[c] && r_addr[c] == 1) begin
        int id = int'(r_wd[c][9:0]);
        if (id < 16) m_sa[c][id] = 0;
        else if (id == 29) m_ta[c] = 0;
        else if (id >= 32 && id < 32 + NS && m_act[id-32] && m_own[id-32] == c) m_act[id-32] = 0;
      end
    end
    for (int c = 0; c < NC; c++)
      if (r_vld[c] && r_wr[c] && r_addr[c] == 2)
        for (int t = 0; t < NC; t++)
          if (r_wd[c][16+t]) m_sp[t][r_wd[c][3:0]] = 1;
    for (int c = 0; c < NC; c++) begin
      if (r_vld[c] && r_wr[c] && r_addr[c] == 3)
        for (int s = 0; s < NS; s++) m_en[s] = r_wd[c][s];
      if (r_vld[c] && r_wr[c] && r_addr[c] == 4)
        m_tgt[r_wd[c][4:0]] = r_wd[c][19:16];
    end
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      got[c] = int'(rsp_data[c*32 +: 32]);
      chk(rsp_vld[c] == ev[c], "R2", int'(rsp_vld[c]), int'(ev[c]));
      if (ev[c]) chk(got[c] == ed[c], tag, got[c], ed[c]);
      chk(irq[c] == m_irq(c), "R9", int'(irq[c]), int'(m_irq(c)));
    end
    clr_req();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < NS; s++) begin m_en[s] = 0; m_tgt[s] = 0; m_act[s] = 0; m_own[s] = 0; end
    for (int c = 0; c < NC; c++) begin m_sp[c] = 0; m_sa[c] = 0; m_ta[c] = 0; m_last[c] = 1023; end
    spi = '0; tmr = '0; clr_req();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk(irq == 0, "R1", int'(irq), 0);
    chk(rsp_vld == 0, "R1", int'(rsp_vld), 0);
    put(0, 0, 0, 0); step("R1");
    chk(got[0] == 1023, "R1", got[0], 1023);
    put(1, 0, 7, 0); step("R2");
    chk(got[1] == 0, "R2", got[1], 0);

    // R3: enable and route
    spi[3] = 1;
    put(0, 1, 3, (1 << 3) | (1 << 5)); step("R3");
    put(2, 1, 4, 3 | (4'b0010 << 16)); step("R3");
    chk(irq == 4'b0010, "R3", int'(irq), 2);
    put(0, 0, 0, 0); step("R3");
    chk(got[0] == 1023, "R3", got[0], 1023);
    put(1, 0, 0, 0); step("R3");
    chk(got[1] == 35, "R3", got[1], 35);

    // R6: service blocks redelivery; foreign completion ignored
    put(0, 1, 4, 3 | (4'b1111 << 16)); step("R6");
    put(2, 0, 0, 0); step("R6");
    chk(got[2] == 1023, "R6", got[2], 1023);
    put(0, 1, 1, 35); step("R6");
    put(3, 0, 0, 0); step("R6");
    chk(got[3] == 1023, "R6", got[3], 1023);
    put(1, 1, 1, 35); step("R6");
    put(3, 0, 0, 0); step("R6");
    chk(got[3] == 35, "R6", got[3], 35);
    put(3, 1, 1, 35); step("R6");

    // R4: simultaneous claimers get distinct IDs, third gets idle
    spi[5] = 1;
    put(0, 1, 4, 5 | (4'b1111 << 16)); step("R4");
    put(0, 0, 0, 0); put(1, 0, 0, 0); put(2, 0, 0, 0); step("R4");
    chk(got[0] == 35, "R4", got[0], 35);
    chk(got[1] == 37, "R4", got[1], 37);
    chk(got[2] == 1023, "R4", got[2], 1023);
    put(0, 1, 1, 35); put(1, 1, 1, 37); step("R4");

    // R11: lines drop before any claim
    spi = '0;
    put(0, 0, 0, 0); step("R11");
    chk(got[0] == 1023, "R11", got[0], 1023);
    chk(irq == 0, "R11", int'(irq), 0);

    // R7 and R5: software interrupt beats shared source
    spi[3] = 1;
    put(2, 1, 2, 7 | (4'b1001 << 16)); step("R7");
    chk(irq == 4'b1111, "R7", int'(irq), 15);
    put(1, 0, 0, 0); step("R7");
    chk(got[1] == 35, "R7", got[1], 35);
    put(3, 0, 0, 0); put(2, 0, 0, 0); step("R5");
    chk(got[3] == 7, "R5", got[3], 7);
    chk(got[2] == 1023, "R7", got[2], 1023);
    put(0, 0, 0, 0); step("R7");
    chk(got[0] == 7, "R7", got[0], 7);
    put(0, 1, 1, 7); put(3, 1, 1, 7); step("R7");

    // R8: timer only on its own CPU
    tmr[2] = 1;
    put(3, 0, 0, 0); step("R8");
    chk(got[3] == 1023, "R8", got[3], 1023);
    put(2, 0, 0, 0); step("R8");
    chk(got[2] == 29, "R8", got[2], 29);
    put(2, 1, 1, 29); step("R8");
    tmr[2] = 0;
    put(1, 1, 1, 35); step("R8");

    // R10: same-cycle enable writes, highest CPU wins
    put(0, 1, 3, -1); put(3, 1, 3, 0); step("R10");
    put(1, 0, 0, 0); step("R10");
    chk(got[1] == 1023, "R10", got[1], 1023);

    // random mix checked against the bench model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 6 == 0) spi = spi ^ ($urandom & $urandom);
      if ($urandom % 16 == 0) tmr = 4'($urandom);
      for (int c = 0; c < NC; c++) begin
        int r = int'($urandom % 20);
        if (r < 6) put(c, 0, 0, 0);
        else if (r < 9) put(c, 1, 1, m_last[c]);
        else if (r == 9) put(c, 1, 1, int'($urandom % 64));
        else if (r == 10) put(c, 1, 2, int'($urandom % 16) | int'(($urandom % 16) << 16));
        else if (r == 11) put(c, 1, 3, int'($urandom | $urandom));
        else if (r == 12) put(c, 1, 4, int'($urandom % 32) | int'(($urandom % 16) << 16));
        else if (r == 13) put(c, 0, 5, 0);
      end
      step("R4");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule